// File: doc/BRIEF.md
# One-Bit Sinc-Cubed Decimator

This block is the first rate-reduction stage behind a pair of single-bit sigma-delta modulators in a stereo audio converter. Each of two channels delivers one bit per modulator clock, qualified by a shared input strobe running at 128 times the audio sample rate. The block low-pass filters each stream with a 64-tap symmetric FIR whose impulse response is three 22-sample boxcars convolved together, giving a third-order sinc response. It emits one signed multi-bit sample per channel for every 16 accepted bits, which is 8 times the audio sample rate.

Because every input is a single bit, each tap either adds or subtracts its coefficient, so there are no multipliers. Four accumulators per channel are staggered by 16 bits. Each one collects a full 64-bit window and then hands its sum to the output register. Only the 32 distinct coefficient values are kept, and a window position is folded onto that half before lookup. The later half-band stages read `out_left` and `out_right` on the cycles when `out_valid` is high.

Top module: `sinc3_decim`

## Requirements
- R1: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A stream of all ones produces +10648 on each output, which is 22 cubed.
- R2: A stream of all zeros produces -10648.
- R3: The coefficient at window position k (0 to 63) equals the number of ways to write k as a sum of three integers, each from 0 to 21. With a single 1 at window position k among zeros, the output is -10648 + 2 * coefficient(k).
- R4: The coefficients are mirror-symmetric: position k equals position 63-k. A strictly alternating stream therefore produces 0, and so does a window whose lower 32 bits are ones and whose upper 32 bits are zeros.
- R5: The first `out_valid` pulse after reset comes in the cycle after the 64th accepted bit. It covers accepted bits 0 to 63, where position k in the window is accepted bit k.
- R6: After the first pulse, one pulse follows each further group of 16 accepted bits. Output number m covers accepted bits 16m to 16m+63.
- R7: A cycle with `in_valid` low has no effect. Its data bits are ignored, no pulse follows it, and the outputs hold their values.
- R8: The left and right channels are filtered independently. Each output depends only on its own input bit.
- R9: While `rst_n` is low (synchronous), `out_valid` and both outputs are 0. After a reset, the window count starts again from zero, including when the reset falls in the middle of a stream.
- R10: The outputs are 15-bit two's complement, and their magnitude never exceeds 10648.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One pair of modulator bits is presented this cycle |
| bit_left | input | 1 | Left modulator bit |
| bit_right | input | 1 | Right modulator bit |
| out_valid | output | 1 | One-cycle pulse marking a new decimated sample |
| out_left | output | 15 | Left sample, signed |
| out_right | output | 15 | Right sample, signed |

## Verification
The hardest case to reach from the ports is a window whose sum depends on a single coefficient. It is also hard to check the accumulators that were still filling when the stream started, or when a reset cut across a window. Single-impulse streams isolate chosen coefficients on each channel at different positions. A reset after 40 bits, followed by a constant stream, shows that no partial sum leaks into the next first output. A stream interleaved with idle cycles, whose data bits oppose the valid data, exposes any strobe gating error. A bench model built from boxcar convolution checks every emitted sample against its own window.

// File: rtl/sinc3_decim_pkg.sv
// Shared constant functions for the sinc-cubed decimator.
// Assumes an even boxcar length, so that the tap count 3*box-2 is even.
package sinc3_decim_pkg;

    // Number of ways to write k as a+b+c with each term in [0, box-1].
    function automatic int box3_coef(input int box, input int k);
        int cnt;
        int d;
        cnt = 0;
        for (int a = 0; a < box; a++) begin
            for (int b = 0; b < box; b++) begin
                d = k - a - b;
                if (d >= 0 && d < box) cnt++;
            end
        end
        return cnt;
    endfunction

    // Length of three convolved boxcars.
    function automatic int tap_count(input int box);
        return 3 * box - 2;
    endfunction

    // Signed width that holds +/- box^3.
    function automatic int out_width(input int box);
        return $clog2(box * box * box + 1) + 1;
    endfunction

    // Unsigned width of the largest (central) coefficient.
    function automatic int coef_width(input int box);
        return $clog2(box3_coef(box, tap_count(box) / 2 - 1) + 1);
    endfunction

endpackage

// File: rtl/sinc3_phase_ctr.sv
// Window position counter shared by both channels.
// Counts accepted bits modulo TAPS and flags the cycles that close a window.
// The first window must be complete before anything is emitted.
// Assumes that DECIM is a power of two and divides TAPS.
module sinc3_phase_ctr #(
    parameter int  TAPS  = 64,
    parameter int  DECIM = 16,
    localparam int IDX_W = $clog2(TAPS),
    localparam int SUB_W = $clog2(DECIM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic [IDX_W-1:0] pos,
    output logic             emit
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

    logic warm;

    // Advance the position on each accepted bit; note when the first window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            warm <= 1'b0;
        end else if (in_valid) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
            if (pos == LAST) warm <= 1'b1;
        end
    end

    // A window closes on every DECIM-th bit, once the first full window has been seen.
    always_comb begin
        emit = in_valid && (pos[SUB_W-1:0] == {SUB_W{1'b1}}) && (warm || pos == LAST);
    end

endmodule

// File: rtl/sinc3_coef_rom.sv
// Constant coefficient lookup.
// Stores only the lower half of the symmetric response and mirrors upper positions onto it.
// Values come from the package function at elaboration.
module sinc3_coef_rom
    import sinc3_decim_pkg::*;
#(
    parameter int  BOX_LEN = 22,
    localparam int TAPS    = tap_count(BOX_LEN),
    localparam int IDX_W   = $clog2(TAPS),
    localparam int UNIQ    = TAPS / 2,
    localparam int U_W     = $clog2(UNIQ),
    localparam int COEF_W  = coef_width(BOX_LEN)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [COEF_W-1:0] coef
);

    logic [COEF_W-1:0] tbl [UNIQ];
    logic [U_W-1:0]    fold;

    for (genvar g = 0; g < UNIQ; g++) begin : g_tbl
        localparam int CV = box3_coef(BOX_LEN, g);
        assign tbl[g] = COEF_W'(CV);
    end

    // Mirror the upper half of the window onto the stored half, then look up.
    always_comb begin
        if (idx >= IDX_W'(UNIQ)) fold = U_W'(IDX_W'(TAPS - 1) - idx);
        else                     fold = idx[U_W-1:0];
        coef = tbl[fold];
    end

endmodule

// File: rtl/sinc3_lane.sv
// One channel of the decimator.
// PHASES accumulators are offset by DECIM bits. Each one adds or subtracts the
// coefficient for its own window position, and clears when its window closes.
// The sum of the closing window is registered when emit is high.
// Assumes that only one accumulator closes on any accepted bit.
module sinc3_lane
    import sinc3_decim_pkg::*;
#(
    parameter int  BOX_LEN = 22,
    parameter int  DECIM   = 16,
    localparam int TAPS    = tap_count(BOX_LEN),
    localparam int IDX_W   = $clog2(TAPS),
    localparam int PHASES  = TAPS / DECIM,
    localparam int COEF_W  = coef_width(BOX_LEN),
    localparam int OUT_W   = out_width(BOX_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    bit_in,
    input  logic [IDX_W-1:0]        pos,
    input  logic                    emit,
    output logic signed [OUT_W-1:0] sample
);

    logic signed [OUT_W-1:0] total [PHASES];
    logic [PHASES-1:0]       fin;
    logic signed [OUT_W-1:0] picked;

    for (genvar j = 0; j < PHASES; j++) begin : g_slot
        localparam int OFF = j * DECIM;

        logic [IDX_W:0]          shifted;
        logic [IDX_W-1:0]        idx;
        logic [COEF_W-1:0]       coef;
        logic signed [OUT_W-1:0] mag;
        logic signed [OUT_W-1:0] term;
        logic signed [OUT_W-1:0] acc_q;

        // Position of the current bit inside this accumulator's window.
        always_comb begin
            shifted = {1'b0, pos} + (IDX_W + 1)'(TAPS - OFF);
            if (shifted >= (IDX_W + 1)'(TAPS)) idx = IDX_W'(shifted - (IDX_W + 1)'(TAPS));
            else                               idx = shifted[IDX_W-1:0];
        end

        sinc3_coef_rom #(.BOX_LEN(BOX_LEN)) u_rom (
            .idx  (idx),
            .coef (coef)
        );

        // Turn the bit into a signed coefficient contribution.
        always_comb begin
            mag  = $signed({{(OUT_W - COEF_W){1'b0}}, coef});
            term = bit_in ? mag : -mag;
        end

        assign total[j] = acc_q + term;
        assign fin[j]   = (idx == IDX_W'(TAPS - 1));

        // Accumulate across the window, then restart from zero after its last bit.
        always_ff @(posedge clk) begin
            if (!rst_n)        acc_q <= '0;
            else if (in_valid) acc_q <= fin[j] ? '0 : total[j];
        end
    end

    // Pick the sum of the window that closes this cycle.
    always_comb begin
        picked = '0;
        for (int j = 0; j < PHASES; j++) begin
            if (fin[j]) picked = total[j];
        end
    end

    // Hold the most recent completed window sum.
    always_ff @(posedge clk) begin
        if (!rst_n)    sample <= '0;
        else if (emit) sample <= picked;
    end

endmodule

// File: rtl/sinc3_decim.sv
// Stereo one-bit sinc-cubed decimator, top level.
// One shared position counter drives two independent channel lanes.
// out_valid pulses in the cycle after each window closes.
module sinc3_decim
    import sinc3_decim_pkg::*;
#(
    parameter int  BOX_LEN = 22,
    parameter int  DECIM   = 16,
    localparam int OUT_W   = out_width(BOX_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    bit_left,
    input  logic                    bit_right,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_left,
    output logic signed [OUT_W-1:0] out_right
);

    localparam int TAPS  = tap_count(BOX_LEN);
    localparam int IDX_W = $clog2(TAPS);
    localparam int CHANS = 2;

    logic [IDX_W-1:0]        pos;
    logic                    emit;
    logic [CHANS-1:0]        bits;
    logic signed [OUT_W-1:0] samp [CHANS];

    assign bits = {bit_right, bit_left};

    sinc3_phase_ctr #(.TAPS(TAPS), .DECIM(DECIM)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .pos      (pos),
        .emit     (emit)
    );

    for (genvar c = 0; c < CHANS; c++) begin : g_lane
        sinc3_lane #(.BOX_LEN(BOX_LEN), .DECIM(DECIM)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .bit_in   (bits[c]),
            .pos      (pos),
            .emit     (emit),
            .sample   (samp[c])
        );
    end

    assign out_left  = samp[0];
    assign out_right = samp[1];

    // Register the emit pulse so that it lines up with the registered samples.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= emit;
    end

endmodule

// File: rtl/sinc3_decim_checker.sv
// Port-level properties of the decimator, attached with bind.
// A counter tracks accepted bits since the last pulse, so the spacing check
// does not depend on a long $past window.
module sinc3_decim_checker
    import sinc3_decim_pkg::*;
#(
    parameter int  BOX_LEN = 22,
    parameter int  DECIM   = 16,
    localparam int OUT_W   = out_width(BOX_LEN),
    localparam int TAPS    = tap_count(BOX_LEN),
    localparam int CNT_W   = $clog2(TAPS + 1) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_left,
    input logic signed [OUT_W-1:0] out_right
);

    localparam int MAXV = BOX_LEN * BOX_LEN * BOX_LEN;

    logic [CNT_W-1:0] since_q;
    logic             primed_q;

    // Count accepted bits since the previous pulse; note when the first pulse has appeared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q  <= '0;
            primed_q <= 1'b0;
        end else begin
            since_q <= (out_valid ? '0 : since_q) + CNT_W'(in_valid);
            if (out_valid) primed_q <= 1'b1;
        end
    end

    // R5 and R6: pulse spacing in accepted bits
    a_r6_cadence: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_q == (primed_q ? CNT_W'(DECIM) : CNT_W'(TAPS))));

    a_r7_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));

    a_r9_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_left == '0 && out_right == '0));

    a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_left <= OUT_W'(MAXV) && out_left >= -OUT_W'(MAXV)
                    && out_right <= OUT_W'(MAXV) && out_right >= -OUT_W'(MAXV)));

endmodule

bind sinc3_decim sinc3_decim_checker #(.BOX_LEN(BOX_LEN), .DECIM(DECIM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/sinc3_decim_bench.sv
// Self-checking bench. It walks a vector table, then runs directed tests for
// reset, impulses and idle gaps. A reference model built from boxcar
// convolution checks every emitted sample.
module sinc3_decim_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               bit_left = 1'b0;
    logic               bit_right = 1'b0;
    logic               out_valid;
    logic signed [14:0] out_left;
    logic signed [14:0] out_right;

    sinc3_decim u_sinc3_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bit_left  (bit_left),
        .bit_right (bit_right),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    typedef struct packed {
        logic [63:0]        lp;
        logic [63:0]        rp;
        logic signed [15:0] el;
        logic signed [15:0] er;
        logic               has;
        logic               gap;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'sd10648, -16'sd10648, 1'b1, 1'b0},
        '{64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 16'sd0, 16'sd10648, 1'b1, 1'b0},
        '{64'h0000_0000_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 16'sd0, 16'sd0, 1'b1, 1'b0},
        '{64'h9E37_79B9_7F4A_7C15, 64'h0F0F_0F0F_0F0F_0F0F, 16'sd0, 16'sd0, 1'b0, 1'b0},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 16'sd10648, 16'sd0, 1'b1, 1'b1}
    };

    int total = 0;
    int bad = 0;
    int h [64];
    bit hist_l [1024];
    bit hist_r [1024];
    int pushed = 0;
    int out_idx = 0;
    int first_l = 0;
    int first_r = 0;
    logic signed [14:0] prev_l = '0;
    logic signed [14:0] prev_r = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference coefficients: three boxcars of length 22 convolved together.
    initial begin
        int t2 [43];
        for (int i = 0; i < 43; i++) begin
            t2[i] = 0;
            for (int a = 0; a < 22; a++) if (i - a >= 0 && i - a < 22) t2[i]++;
        end
        for (int k = 0; k < 64; k++) begin
            h[k] = 0;
            for (int a = 0; a < 22; a++) if (k - a >= 0 && k - a < 43) h[k] += t2[k - a];
        end
    end

    // Monitor: samples a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && out_valid) begin
            int el;
            int er;
            el = 0;
            er = 0;
            chk(in_valid == 1'b1, "R7 pulse after idle cycle", int'(in_valid), 1);
            chk(pushed == 64 + 16 * out_idx, "R5 R6 bits before pulse", pushed, 64 + 16 * out_idx);
            for (int k = 0; k < 64; k++) begin
                el += hist_l[16 * out_idx + k] ? h[k] : -h[k];
                er += hist_r[16 * out_idx + k] ? h[k] : -h[k];
            end
            chk(int'(out_left) == el, "R6 R3 left window sum", int'(out_left), el);
            chk(int'(out_right) == er, "R8 R3 right window sum", int'(out_right), er);
            chk(out_left <= 15'sd10648 && out_left >= -15'sd10648, "R10 left range", int'(out_left), 10648);
            if (out_idx == 0) begin
                first_l = int'(out_left);
                first_r = int'(out_right);
            end
            out_idx++;
        end else if (rst_n) begin
            chk(out_left == prev_l && out_right == prev_r, "R7 hold", int'(out_left), int'(prev_l));
        end
        prev_l = out_left;
        prev_r = out_right;
    end

    task automatic push(input bit l, input bit r, input bit v);
        @(negedge clk);
        in_valid  = v;
        bit_left  = l;
        bit_right = r;
        if (v) begin
            hist_l[pushed] = l;
            hist_r[pushed] = r;
            pushed++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
        chk(out_left == '0 && out_right == '0, "R9 data in reset", int'(out_left), 0);
        pushed = 0;
        out_idx = 0;
        first_l = 0;
        first_r = 0;
        rst_n = 1'b1;
    endtask

    task automatic run_pat(input logic [63:0] lp, input logic [63:0] rp, input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            if (gap) push(~lp[i % 64], ~rp[i % 64], 1'b0);
            push(lp[i % 64], rp[i % 64], 1'b1);
        end
        push(1'b0, 1'b0, 1'b0);
        push(1'b0, 1'b0, 1'b0);
        chk(out_idx == (n - 64) / 16 + 1, "R6 pulse count", out_idx, (n - 64) / 16 + 1);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 R2 R4 R7 R8: table walk
        for (int v = 0; v < 5; v++) begin
            do_reset();
            run_pat(VECS[v].lp, VECS[v].rp, 128, VECS[v].gap);
            if (VECS[v].has) begin
                chk(first_l == int'(VECS[v].el), "R1 R2 R4 left first sample", first_l, int'(VECS[v].el));
                chk(first_r == int'(VECS[v].er), "R1 R2 R4 R8 right first sample", first_r, int'(VECS[v].er));
            end
        end

        // R3: single impulse at distinct positions on each channel
        do_reset();
        run_pat(64'h1 << 20, 64'h1 << 40, 64, 1'b0);
        chk(first_l == -10648 + 2 * h[20], "R3 left impulse", first_l, -10648 + 2 * h[20]);
        chk(first_r == -10648 + 2 * h[40], "R3 right impulse", first_r, -10648 + 2 * h[40]);

        // R3 R4: impulse at an end tap, mirrored on the other channel
        do_reset();
        run_pat(64'h1, 64'h1 << 63, 64, 1'b0);
        chk(first_l == first_r, "R4 mirrored taps", first_l, first_r);
        chk(first_l == -10648 + 2, "R3 end tap", first_l, -10648 + 2);

        // R5: no pulse before the 64th accepted bit
        do_reset();
        for (int i = 0; i < 63; i++) push(1'b1, 1'b1, 1'b1);
        push(1'b0, 1'b0, 1'b0);
        chk(out_idx == 0, "R5 no early pulse", out_idx, 0);
        push(1'b1, 1'b1, 1'b1);
        push(1'b0, 1'b0, 1'b0);
        chk(out_idx == 1 && first_l == 10648, "R5 first pulse", first_l, 10648);

        // R9: reset in the middle of a stream
        do_reset();
        for (int i = 0; i < 40; i++) push(1'b0, 1'b1, 1'b1);
        do_reset();
        run_pat(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64, 1'b0);
        chk(first_l == 10648, "R9 clean restart left", first_l, 10648);
        chk(first_r == -10648, "R9 clean restart right", first_r, -10648);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule